// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM. After reset it owns the memory command bus and takes the device from power-on to its operating state. It keeps the clock enable low and the chip deselected until the power-good input has been high without a break for a set number of clock cycles. It then raises the clock enable, sends one NOP, and issues the initialization commands in their required order. The sequence is a Precharge All, a write of the extended mode register that enables the DLL, and a write of the base mode register with the DLL reset bit set. A 200-cycle lock window of NOPs follows, then a second Precharge All, two Auto Refresh commands, and a last base mode register write with the DLL reset bit cleared.

Each command is followed by a fixed run of NOP cycles. The length depends on the command: a precharge-recovery count, a mode-register-delay count, a refresh-cycle count, or the DLL lock count. The operating mode word and the extended mode word are parameters. When the last mode write and its NOP run are complete, the block raises a done flag. The flag stays high until the next reset. A reset at any point drops the clock enable and starts the sequence again from the power-good wait.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is active, `cke` is low, `csN`, `rasN`, `casN` and `weN` are all high (deselect), and `initDone` is low.
- R2: `cke` stays low and the bus stays deselected until `powerStable` has been high for STABLE_WAIT consecutive clock edges. A low cycle on `powerStable` restarts the count. `cke` rises on the edge after the count completes.
- R3: The first cycle with `cke` high carries a NOP ({csN,rasN,casN,weN}=0111). The next cycle carries a Precharge All (0010 with `addr[10]`=1, other address bits 0, `ba`=0). `cke` never falls again except through reset.
- R4: Each Precharge All is followed by exactly T_RP NOP cycles before the next command.
- R5: The second command is a mode register set (0000) with `ba`=01 and `addr` equal to EXT_MODE_WORD with bit 0 forced to 0 (DLL enabled). It is followed by exactly T_MRD NOP cycles.
- R6: The third command is a mode register set with `ba`=00 and `addr` equal to MODE_WORD with bit 8 forced to 1 (DLL reset). It is followed by exactly DLL_LOCK NOP cycles, during which no other command appears.
- R7: The command after the DLL lock window is a second Precharge All.
- R8: The second precharge is followed by two Auto Refresh commands (0001, `addr`=0, `ba`=0). Each refresh is followed by exactly T_RFC NOP cycles.
- R9: The last command is a mode register set with `ba`=00 and `addr` equal to MODE_WORD with bit 8 forced to 0. It is followed by exactly T_MRD NOP cycles.
- R10: `initDone` is low until the T_MRD NOPs after the last mode write have been driven. It rises on the next cycle and stays high. While it is high, the bus carries NOP with `cke` high.
- R11: Reset asserted in the middle of the sequence immediately returns the outputs to the R1 state. After release, the whole sequence repeats from the R2 wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, same as the memory clock |
| rstN | input | 1 | Active-low asynchronous reset |
| powerStable | input | 1 | High while supplies, reference and clock are stable |
| cke | output | 1 | Memory clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address; selects the mode register during mode writes |
| addr | output | ROW_W | Address bus; carries the mode word or the precharge-all bit |
| initDone | output | 1 | High once initialization is complete |

## Verification
The hardest situation to reach from the ports is a reset that lands inside the 200-cycle DLL lock window. The block has already committed the DLL-reset mode write there and is holding NOPs. The stimulus keeps `powerStable` high and runs the sequence until the third command has been seen plus a fixed number of cycles, then pulses reset in the middle of the window. The bench then checks the full sequence again, including the length of the wait. A second hard case is a glitch on `powerStable` partway through the stable-power count. The stimulus drops the input for one cycle and checks that the wait restarts from its full length.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_MRS,
    CMD_REF
  } cmdKind_e;

  typedef enum logic [1:0] {
    GAP_RP,
    GAP_MRD,
    GAP_DLL,
    GAP_RFC
  } gapKind_e;

  typedef enum logic [1:0] {
    ADR_ZERO,
    ADR_EMR,
    ADR_MR_DLL,
    ADR_MR_RUN
  } adrSel_e;

  typedef struct packed {
    cmdKind_e cmd;
    adrSel_e  adr;
    logic     ckeOn;
    logic     loadGap;
    gapKind_e gap;
    logic     reloadWait;
    logic     countDown;
    logic     done;
  } seqStrobe_t;

endpackage

// File: rtl/ddr_pwrup_ctrl.sv
module ddr_pwrup_ctrl
  import ddr_pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerStable,
  input  logic       cntLast,
  output seqStrobe_t st
);

  typedef enum logic [3:0] {
    P_WAIT, P_NOP, P_PRE1, P_EMR, P_MRDLL,
    P_PRE2, P_REF1, P_REF2, P_MRRUN, P_DONE
  } phase_e;

  phase_e phase, phaseNext;
  logic   gapping, gapNext;

  function automatic phase_e nextPhase(input phase_e p);
    case (p)
      P_WAIT:  return P_NOP;
      P_NOP:   return P_PRE1;
      P_PRE1:  return P_EMR;
      P_EMR:   return P_MRDLL;
      P_MRDLL: return P_PRE2;
      P_PRE2:  return P_REF1;
      P_REF1:  return P_REF2;
      P_REF2:  return P_MRRUN;
      default: return P_DONE;
    endcase
  endfunction

  always_comb begin
    st = '{cmd: CMD_NOP, adr: ADR_ZERO, ckeOn: 1'b1, loadGap: 1'b0,
           gap: GAP_RP, reloadWait: 1'b0, countDown: 1'b0, done: 1'b0};
    phaseNext = phase;
    gapNext   = gapping;
    if (gapping) begin
      if (cntLast) begin
        gapNext   = 1'b0;
        phaseNext = nextPhase(phase);
      end else begin
        st.countDown = 1'b1;
      end
    end else begin
      case (phase)
        P_WAIT: begin
          st.cmd   = CMD_DESEL;
          st.ckeOn = 1'b0;
          if (!powerStable)  st.reloadWait = 1'b1;
          else if (cntLast)  phaseNext = P_NOP;
          else               st.countDown = 1'b1;
        end
        P_NOP: phaseNext = P_PRE1;
        P_PRE1, P_PRE2: begin
          st.cmd = CMD_PRE; st.loadGap = 1'b1; st.gap = GAP_RP; gapNext = 1'b1;
        end
        P_EMR: begin
          st.cmd = CMD_MRS; st.adr = ADR_EMR;
          st.loadGap = 1'b1; st.gap = GAP_MRD; gapNext = 1'b1;
        end
        P_MRDLL: begin
          st.cmd = CMD_MRS; st.adr = ADR_MR_DLL;
          st.loadGap = 1'b1; st.gap = GAP_DLL; gapNext = 1'b1;
        end
        P_REF1, P_REF2: begin
          st.cmd = CMD_REF; st.loadGap = 1'b1; st.gap = GAP_RFC; gapNext = 1'b1;
        end
        P_MRRUN: begin
          st.cmd = CMD_MRS; st.adr = ADR_MR_RUN;
          st.loadGap = 1'b1; st.gap = GAP_MRD; gapNext = 1'b1;
        end
        default: st.done = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= P_WAIT;
      gapping <= 1'b0;
    end else begin
      phase   <= phaseNext;
      gapping <= gapNext;
    end
  end

  // R2: a missing power-good keeps the sequencer in its wait phase
  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_WAIT && !gapping && !powerStable) |=> (phase == P_WAIT));

  // R10: the finished phase is never left without reset
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == P_DONE) |=> (phase == P_DONE));

endmodule

// File: rtl/ddr_pwrup_dp.sv
module ddr_pwrup_dp
  import ddr_pwrup_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int STABLE_WAIT = 20000,
  parameter int DLL_LOCK    = 200,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 8,
  parameter int T_MRD       = 2,
  parameter logic [ROW_W-1:0] MODE_WORD     = 13'h0032,
  parameter logic [ROW_W-1:0] EXT_MODE_WORD = 13'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  output logic              cntLast,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              initDone
);

  localparam int DLL_RST_BIT = 8;
  localparam int PRE_ALL_BIT = 10;
  localparam int DLL_EN_BIT  = 0;
  localparam int M1   = (STABLE_WAIT > DLL_LOCK) ? STABLE_WAIT : DLL_LOCK;
  localparam int M2   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int M3   = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int MAXC = (M1 > M3) ? M1 : M3;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [ROW_W-1:0] DLL_RST_MASK = ROW_W'(1) << DLL_RST_BIT;
  localparam logic [ROW_W-1:0] PRE_ALL_MASK = ROW_W'(1) << PRE_ALL_BIT;
  localparam logic [ROW_W-1:0] DLL_EN_MASK  = ROW_W'(1) << DLL_EN_BIT;
  localparam logic [BANK_W-1:0] BA_EMR = BANK_W'(1);

  logic [CW-1:0]     cnt, gapVal;
  logic [3:0]        pinsNext;
  logic [ROW_W-1:0]  addrNext;
  logic [BANK_W-1:0] baNext;

  always_comb begin
    case (st.gap)
      GAP_RP:  gapVal = CW'(T_RP);
      GAP_MRD: gapVal = CW'(T_MRD);
      GAP_DLL: gapVal = CW'(DLL_LOCK);
      default: gapVal = CW'(T_RFC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= CW'(STABLE_WAIT);
    else if (st.reloadWait)  cnt <= CW'(STABLE_WAIT);
    else if (st.loadGap)     cnt <= gapVal;
    else if (st.countDown)   cnt <= cnt - 1'b1;
  end

  assign cntLast = (cnt == CW'(1));

  always_comb begin
    case (st.cmd)
      CMD_DESEL: pinsNext = 4'b1111;
      CMD_PRE:   pinsNext = 4'b0010;
      CMD_MRS:   pinsNext = 4'b0000;
      CMD_REF:   pinsNext = 4'b0001;
      default:   pinsNext = 4'b0111;
    endcase
    baNext = '0;
    case (st.adr)
      ADR_EMR: begin
        addrNext = EXT_MODE_WORD & ~DLL_EN_MASK;
        baNext   = BA_EMR;
      end
      ADR_MR_DLL: addrNext = MODE_WORD | DLL_RST_MASK;
      ADR_MR_RUN: addrNext = MODE_WORD & ~DLL_RST_MASK;
      default:    addrNext = (st.cmd == CMD_PRE) ? PRE_ALL_MASK : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b0;
      {csN, rasN, casN, weN} <= 4'b1111;
      ba       <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      cke      <= st.ckeOn;
      {csN, rasN, casN, weN} <= pinsNext;
      ba       <= baNext;
      addr     <= addrNext;
      initDone <= st.done;
    end
  end

  // checker state: cycles left in the DLL lock window, from the pins
  logic          isNop, isPre, isDllMrs;
  logic [CW-1:0] dllLeft;
  assign isNop    = !csN && rasN && casN && weN;
  assign isPre    = !csN && !rasN && casN && !weN;
  assign isDllMrs = !csN && !rasN && !casN && !weN && (ba == '0) && addr[DLL_RST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dllLeft <= '0;
    else if (isDllMrs)         dllLeft <= CW'(DLL_LOCK);
    else if (dllLeft != '0)    dllLeft <= dllLeft - 1'b1;
  end

  p_desel_low_cke_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (csN && !initDone));
  p_cke_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);
  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> addr[PRE_ALL_BIT]);
  p_cmd_then_nop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !csN && !isNop) |=> isNop);
  p_dll_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dllLeft != '0) |-> isNop);
  p_done_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cke && isNop));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int STABLE_WAIT = 20000,
  parameter int DLL_LOCK    = 200,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 8,
  parameter int T_MRD       = 2,
  parameter logic [ROW_W-1:0] MODE_WORD     = 13'h0032,
  parameter logic [ROW_W-1:0] EXT_MODE_WORD = 13'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerStable,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              initDone
);

  seqStrobe_t strobes;
  logic       cntLast;

  ddr_pwrup_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .powerStable (powerStable),
    .cntLast     (cntLast),
    .st          (strobes)
  );

  ddr_pwrup_dp #(
    .BANK_W        (BANK_W),
    .ROW_W         (ROW_W),
    .STABLE_WAIT   (STABLE_WAIT),
    .DLL_LOCK      (DLL_LOCK),
    .T_RP          (T_RP),
    .T_RFC         (T_RFC),
    .T_MRD         (T_MRD),
    .MODE_WORD     (MODE_WORD),
    .EXT_MODE_WORD (EXT_MODE_WORD)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .cntLast  (cntLast),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .addr     (addr),
    .initDone (initDone)
  );

  initial begin
    assert (T_RP >= 1 && T_RFC >= 1 && T_MRD >= 1 && DLL_LOCK >= T_MRD && STABLE_WAIT >= 1)
      else $error("sequencer gap parameters out of range");
  end

endmodule

// File: tb/test_ddr_pwrup_seq.sv
module test_ddr_pwrup_seq;

  localparam int W      = 30;
  localparam int DLL    = 200;
  localparam int TRP    = 3;
  localparam int TRFC   = 9;
  localparam int TMRD   = 2;
  localparam logic [12:0] MW  = 13'h00A3;
  localparam logic [12:0] EMW = 13'h0003;

  logic clk = 1'b0;
  logic rstN, powerStable;
  logic cke, csN, rasN, casN, weN, initDone;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #10 clk = ~clk;

  ddr_pwrup_seq #(
    .STABLE_WAIT (W), .DLL_LOCK (DLL), .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD),
    .MODE_WORD (MW), .EXT_MODE_WORD (EMW)
  ) i_ddr_pwrup_seq (
    .clk (clk), .rstN (rstN), .powerStable (powerStable),
    .cke (cke), .csN (csN), .rasN (rasN), .casN (casN), .weN (weN),
    .ba (ba), .addr (addr), .initDone (initDone)
  );

  typedef struct {
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [12:0] addr;
    int          gapBefore;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  int  nopRun  = 0;
  bit  doneSeen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // driver side of the scoreboard: the full expected command list
  task automatic loadExpected();
    expQ.delete();
    doneSeen = 1'b0;
    expQ.push_back('{4'b0010, 2'b00, 13'h0400, 1,    "R3 first precharge"});
    expQ.push_back('{4'b0000, 2'b01, EMW & ~13'h0001, TRP, "R4 R5 ext mode write"});
    expQ.push_back('{4'b0000, 2'b00, MW | 13'h0100, TMRD, "R5 R6 dll reset write"});
    expQ.push_back('{4'b0010, 2'b00, 13'h0400, DLL,  "R6 R7 second precharge"});
    expQ.push_back('{4'b0001, 2'b00, 13'h0000, TRP,  "R4 R8 first refresh"});
    expQ.push_back('{4'b0001, 2'b00, 13'h0000, TRFC, "R8 second refresh"});
    expQ.push_back('{4'b0000, 2'b00, MW & ~13'h0100, TRFC, "R8 R9 run mode write"});
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (!cke) begin
        nopRun = 0;
        if (initDone) check(1'b0, "R10", "done with cke low", 1, 0);
      end else begin
        if (initDone && !doneSeen) begin
          doneSeen = 1'b1;
          check(expQ.size() == 0, "R10", "done before last command", expQ.size(), 0);
          check(nopRun == TMRD, "R9", "nops after last mode write", nopRun, TMRD);
        end
        if ({csN, rasN, casN, weN} == 4'b0111) begin
          nopRun++;
        end else begin
          if (expQ.size() == 0) begin
            check(1'b0, "R10", "unexpected command", {csN, rasN, casN, weN}, 4'b0111);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check({csN, rasN, casN, weN} == it.pins, it.tag, "command pins",
                  {csN, rasN, casN, weN}, it.pins);
            check(ba == it.ba && addr == it.addr, it.tag, "bank/address",
                  {ba, addr}, {it.ba, it.addr});
            check(nopRun == it.gapBefore, it.tag, "nop gap before", nopRun, it.gapBefore);
          end
          nopRun = 0;
        end
      end
    end
  end

  task automatic countLowCke(input string req);
    int n = 0;
    @(negedge clk);
    while (!cke && n < W + 50) begin
      n++;
      @(negedge clk);
    end
    check(n == W, req, "cycles before cke rise", n, W);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!doneSeen && n < 2000) begin
      n++;
      @(negedge clk);
    end
    check(doneSeen, req, "init done reached", doneSeen, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    finishUp();
  end

  initial begin
    rstN = 1'b0;
    powerStable = 1'b0;
    repeat (3) @(negedge clk);
    check(!cke && csN && rasN && casN && weN && !initDone, "R1", "reset outputs",
          {cke, csN, rasN, casN, weN, initDone}, 6'b011110);
    rstN = 1'b1;

    // R2: no power-good, bus must stay idle
    begin
      bit ok = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (cke || !csN) ok = 1'b0;
      end
      check(ok, "R2", "idle without power good", {cke, csN}, 2'b01);
    end

    // R2: glitch partway through the wait restarts it
    powerStable = 1'b1;
    repeat (W - 5) @(negedge clk);
    powerStable = 1'b0;
    @(negedge clk);
    check(!cke && csN, "R2", "cke after glitch", {cke, csN}, 2'b01);
    loadExpected();
    powerStable = 1'b1;
    countLowCke("R2");
    waitDone("R10");

    begin
      bit ok = 1'b1;
      repeat (25) begin
        @(negedge clk);
        if (!initDone || !cke || {csN, rasN, casN, weN} != 4'b0111) ok = 1'b0;
      end
      check(ok, "R10", "done held with nop bus", {initDone, cke}, 2'b11);
    end

    // R11: reset inside the DLL lock window, then a full rerun
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    loadExpected();
    countLowCke("R11");
    repeat (60) @(negedge clk);
    check(expQ.size() == 4, "R11", "inside dll window", expQ.size(), 4);
    rstN = 1'b0;
    #1;
    check(!cke && csN && !initDone, "R11", "async reset outputs",
          {cke, csN, initDone}, 3'b010);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    loadExpected();
    countLowCke("R11");
    waitDone("R11");
    repeat (5) @(negedge clk);
    check(initDone && expQ.size() == 0, "R11", "rerun complete", initDone, 1);
    finishUp();
  end

endmodule